// File: doc/BRIEF.md
# Synchronized Clock Stop Gating Controller

This block sits between the internal clock sources of a clock generator and its output pads. It gates a bank of CPU clock outputs and a bank of PCI clock outputs in response to two asynchronous, active-low stop pins. It also applies a per-output (or per-group) enable mask to every clock it drives and a global three-state control that withdraws all output enables. Four source clocks come in: the CPU clock, the PCI clock, the buffered SDRAM clock and the reference clock. A PCI output that never stops is derived from the PCI clock.

The stop pins take effect only when the latched mobile-mode flag is set. The CPU stop request is first synchronized and sampled on the PCI clock, which is the same clock that drives the free-running output. It is then carried into the CPU domain. The PCI stop request is synchronized and applied in the PCI domain. Every gate changes its enable only while its source clock is LOW. A stopped or disabled output therefore rests LOW and never emits a shortened pulse. In desktop mode, two of the SDRAM outputs take the place of the stop pins. In mobile mode, those two outputs are held LOW and their output enables are withdrawn.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst` is high, every gated clock output is LOW and every output enable is 0.
- R2: With `mobile`=1, after `cpu_stop_n` falls, both CPU outputs give their last high pulse on the second `cpu_clk` rising edge that follows the second `pci_clk` rising edge after the fall. From the next `cpu_clk` edge onward they stay LOW.
- R3: With `mobile`=1, after `cpu_stop_n` rises, the CPU outputs remain LOW through that same second `cpu_clk` edge. Their first high pulse comes on the following `cpu_clk` edge.
- R4: With `mobile`=1, after `pci_stop_n` falls, the five gated PCI outputs pulse on the first two `pci_clk` rising edges after the fall. They are LOW from the third edge onward.
- R5: With `mobile`=1, after `pci_stop_n` rises, the gated PCI outputs stay LOW on the first two `pci_clk` rising edges after the rise. They pulse again from the third edge.
- R6: `pci_stop_n` never affects `pcif_o` or the CPU outputs, and `cpu_stop_n` never affects any PCI output.
- R7: With `mobile`=0, both stop pins are ignored and all enabled outputs run.
- R8: An output whose enable bit is 0 drives a static LOW. The enable bits map as follows: `cpu_en[i]` to `cpu_o[i]`, `pci_en[i]` to `pci_o[i]`, `ref_en[i]` to `ref_o[i]`, `pcif_en` to `pcif_o`, and `apic_en` to `apic_o`.
- R9: The SDRAM group enables map as follows: `sdr_grp_en[0]` gates bits 0-3, `sdr_grp_en[1]` gates bits 4-7, `sdr_grp_en[2]` gates bits 8, 9, 12 and 13, and `sdr_grp_en[3]` gates bits 10 and 11.
- R10: With `mobile`=1, `sdr_o[11:10]` are LOW and `sdr_oe[11:10]` are 0 regardless of `sdr_grp_en[3]`.
- R11: With `tristate`=1, every output enable goes to 0 at the next rising edge of its own source clock. With `tristate`=0, every output enable is 1, except those excluded by R10.
- R12: Every high pulse on a gated output lasts exactly one full high phase of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| cpu_clk | input | 1 | Internal CPU clock source |
| pci_clk | input | 1 | Internal PCI clock source; also the stop-sampling clock |
| buf_clk | input | 1 | Buffered SDRAM clock source |
| ref_clk | input | 1 | Reference clock source |
| mobile | input | 1 | Latched mode flag: 1 enables the stop pins |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU clock stop request |
| pci_stop_n | input | 1 | Asynchronous active-low PCI clock stop request |
| tristate | input | 1 | 1 withdraws every output enable |
| cpu_en | input | N_CPU | Per-output CPU clock enables |
| pcif_en | input | 1 | Free-running PCI output enable |
| pci_en | input | N_PCI | Per-output gated PCI clock enables |
| sdr_grp_en | input | 4 | SDRAM group enables |
| ref_en | input | N_REF | Per-output reference clock enables |
| apic_en | input | 1 | Interrupt-controller clock enable |
| cpu_o | output | N_CPU | Gated CPU clocks |
| pcif_o | output | 1 | Free-running PCI clock |
| pci_o | output | N_PCI | Stoppable PCI clocks |
| sdr_o | output | 14 | Gated SDRAM clocks |
| ref_o | output | N_REF | Gated reference clocks |
| apic_o | output | 1 | Gated interrupt-controller clock |
| cpu_oe | output | 1 | Output enable for the CPU clock pads |
| pcif_oe | output | 1 | Output enable for the free-running PCI pad |
| pci_oe | output | 1 | Output enable for the gated PCI pads |
| sdr_oe | output | 14 | Per-pad SDRAM output enables |
| ref_oe | output | 1 | Output enable for the reference pads |
| apic_oe | output | 1 | Output enable for the interrupt-controller pad |

## Verification
Each stop pin is toggled alone, then both together, then both in desktop mode. Comparing these cases separates a correct gate from one wired to the wrong request, and from a design that ignores the mode flag. Edge-accurate probes are placed around the synchronizer boundaries. These tell a correct two-stage crossing from one that is a stage short or a stage long. Sparse and alternating enable patterns, with the mobile flag both set and clear, expose swapped bit or group mappings and a desktop-only group that leaks into mobile mode. A pulse-width monitor catches any gate that changes while its clock is high.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  localparam int SDR_N     = 14;
  localparam int SDR_GRPS  = 4;
  localparam int DESK_GRP  = 3;

  // Group index of each SDRAM output; the desktop-only pair shares the stop pins.
  function automatic int sdr_group(input int idx);
    if (idx < 4)                  return 0;
    else if (idx < 8)             return 1;
    else if (idx == 10 || idx == 11) return DESK_GRP;
    else                          return 2;
  endfunction

  function automatic logic [SDR_N-1:0] desk_mask();
    logic [SDR_N-1:0] m;
    for (int i = 0; i < SDR_N; i++) m[i] = (sdr_group(i) == DESK_GRP);
    return m;
  endfunction
endpackage

// File: rtl/clk_stop_sync.sv
`timescale 1ns/1ps
// Two-flop level synchronizer with a configurable reset level.
module clk_stop_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clk_stop_gatebank.sv
`timescale 1ns/1ps
// A bank of clock gates sharing one source clock. Each enable is captured on
// the falling edge, so it only moves while the source is LOW.
module clk_stop_gatebank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] en_req,
  output logic [W-1:0] gate_q,
  output logic [W-1:0] clk_o
);
  always_ff @(negedge clk) begin
    if (rst) gate_q <= '0;
    else     gate_q <= en_req;
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_and
    assign clk_o[gi] = clk & gate_q[gi];
  end
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int N_CPU = 2,
  parameter int N_PCI = 5,
  parameter int N_REF = 2
) (
  input  logic                rst,
  input  logic                cpu_clk,
  input  logic                pci_clk,
  input  logic                buf_clk,
  input  logic                ref_clk,
  input  logic                mobile,
  input  logic                cpu_stop_n,
  input  logic                pci_stop_n,
  input  logic                tristate,
  input  logic [N_CPU-1:0]    cpu_en,
  input  logic                pcif_en,
  input  logic [N_PCI-1:0]    pci_en,
  input  logic [SDR_GRPS-1:0] sdr_grp_en,
  input  logic [N_REF-1:0]    ref_en,
  input  logic                apic_en,
  output logic [N_CPU-1:0]    cpu_o,
  output logic                pcif_o,
  output logic [N_PCI-1:0]    pci_o,
  output logic [SDR_N-1:0]    sdr_o,
  output logic [N_REF-1:0]    ref_o,
  output logic                apic_o,
  output logic                cpu_oe,
  output logic                pcif_oe,
  output logic                pci_oe,
  output logic [SDR_N-1:0]    sdr_oe,
  output logic                ref_oe,
  output logic                apic_oe
);
  localparam int RCLK_W = N_REF + 1;
  localparam logic [SDR_N-1:0] DESK_MASK = desk_mask();

  // Stop request paths: CPU request sampled on the PCI clock, then carried over.
  logic cstop_pci, cstop_cpu, pstop_pci;

  clk_stop_sync #(.W(1), .RST_VAL(1'b1)) u_csync_pci (
    .clk(pci_clk), .rst(rst), .d(cpu_stop_n), .q(cstop_pci));
  clk_stop_sync #(.W(1), .RST_VAL(1'b1)) u_csync_cpu (
    .clk(cpu_clk), .rst(rst), .d(cstop_pci), .q(cstop_cpu));
  clk_stop_sync #(.W(1), .RST_VAL(1'b1)) u_psync (
    .clk(pci_clk), .rst(rst), .d(pci_stop_n), .q(pstop_pci));

  logic cpu_run, pci_run;
  assign cpu_run = !mobile || cstop_cpu;
  assign pci_run = !mobile || pstop_pci;

  // Enable requests
  logic [N_CPU-1:0]  cpu_req;
  logic [N_PCI-1:0]  pci_req;
  logic [SDR_N-1:0]  sdr_req;
  logic [SDR_N-1:0]  sdr_grp_bits;
  logic [RCLK_W-1:0] rclk_req;

  assign cpu_req  = cpu_en & {N_CPU{cpu_run}};
  assign pci_req  = pci_en & {N_PCI{pci_run}};
  assign rclk_req = {apic_en, ref_en};

  for (genvar si = 0; si < SDR_N; si++) begin : g_sdr_map
    assign sdr_grp_bits[si] = sdr_grp_en[sdr_group(si)];
  end
  assign sdr_req = sdr_grp_bits & ~(DESK_MASK & {SDR_N{mobile}});

  // Gate banks, one per source clock
  logic [N_CPU-1:0]  cpu_gate;
  logic [0:0]        pcif_gate;
  logic [N_PCI-1:0]  pci_gate;
  logic [SDR_N-1:0]  sdr_gate;
  logic [RCLK_W-1:0] rclk_gate;
  logic [RCLK_W-1:0] rclk_o;
  logic [0:0]        pcif_vec;

  clk_stop_gatebank #(.W(N_CPU)) u_cpu_gate (
    .clk(cpu_clk), .rst(rst), .en_req(cpu_req), .gate_q(cpu_gate), .clk_o(cpu_o));
  clk_stop_gatebank #(.W(1)) u_pcif_gate (
    .clk(pci_clk), .rst(rst), .en_req(pcif_en), .gate_q(pcif_gate), .clk_o(pcif_vec));
  clk_stop_gatebank #(.W(N_PCI)) u_pci_gate (
    .clk(pci_clk), .rst(rst), .en_req(pci_req), .gate_q(pci_gate), .clk_o(pci_o));
  clk_stop_gatebank #(.W(SDR_N)) u_sdr_gate (
    .clk(buf_clk), .rst(rst), .en_req(sdr_req), .gate_q(sdr_gate), .clk_o(sdr_o));
  clk_stop_gatebank #(.W(RCLK_W)) u_rclk_gate (
    .clk(ref_clk), .rst(rst), .en_req(rclk_req), .gate_q(rclk_gate), .clk_o(rclk_o));

  assign pcif_o = pcif_vec[0];
  assign ref_o  = rclk_o[N_REF-1:0];
  assign apic_o = rclk_o[N_REF];

  // Registered output enables, each in the domain of its pads
  always_ff @(posedge cpu_clk) begin
    if (rst) cpu_oe <= 1'b0;
    else     cpu_oe <= !tristate;
  end

  always_ff @(posedge pci_clk) begin
    if (rst) begin
      pcif_oe <= 1'b0;
      pci_oe  <= 1'b0;
    end else begin
      pcif_oe <= !tristate;
      pci_oe  <= !tristate;
    end
  end

  always_ff @(posedge buf_clk) begin
    if (rst) sdr_oe <= '0;
    else     sdr_oe <= {SDR_N{!tristate}} & ~(DESK_MASK & {SDR_N{mobile}});
  end

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      ref_oe  <= 1'b0;
      apic_oe <= 1'b0;
    end else begin
      ref_oe  <= !tristate;
      apic_oe <= !tristate;
    end
  end
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk
  import clk_stop_pkg::*;
#(
  parameter int N_CPU = 2,
  parameter int N_PCI = 5
) (
  input logic             rst,
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             buf_clk,
  input logic             mobile,
  input logic             pci_stop_n,
  input logic             tristate,
  input logic             pcif_en,
  input logic [N_CPU-1:0] cpu_en,
  input logic             cpu_oe,
  input logic [SDR_N-1:0] sdr_oe,
  input logic [N_CPU-1:0] cpu_gate,
  input logic [N_PCI-1:0] pci_gate,
  input logic [0:0]       pcif_gate
);
  // R4
  pci_stop_hold_chk: assert property (@(posedge pci_clk) disable iff (rst)
    (mobile && $past(mobile) && $past(mobile, 2) && !pci_stop_n && !$past(pci_stop_n)
     && !$past(pci_stop_n, 2) && !$past(rst) && !$past(rst, 2)) |-> (pci_gate == '0));

  // R6
  pcif_free_run_chk: assert property (@(posedge pci_clk) disable iff (rst)
    (pcif_en && $past(pcif_en) && !$past(rst)) |-> pcif_gate[0]);

  // R7
  desk_cpu_run_chk: assert property (@(posedge cpu_clk) disable iff (rst)
    (!mobile && !$past(mobile) && cpu_en == {N_CPU{1'b1}} && $past(cpu_en) == {N_CPU{1'b1}}
     && !$past(rst)) |-> (cpu_gate == {N_CPU{1'b1}}));

  // R11
  cpu_tri_oe_chk: assert property (@(posedge cpu_clk) disable iff (rst)
    $past(tristate) |-> !cpu_oe);

  // R10
  sdr_mobile_oe_chk: assert property (@(posedge buf_clk) disable iff (rst)
    $past(mobile) |-> (sdr_oe[11:10] == 2'b00));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (.*);

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/1ps
module tb_clk_stop_gate;
  import clk_stop_pkg::*;
  localparam int N_CPU = 2, N_PCI = 5, N_REF = 2;
  localparam int ACT_W = N_CPU + 1 + N_PCI + N_REF + 1 + SDR_N;
  localparam int OE_W  = 5 + SDR_N;

  logic rst, cpu_clk, pci_clk, buf_clk, ref_clk;
  logic mobile, cpu_stop_n, pci_stop_n, tristate;
  logic [N_CPU-1:0] cpu_en;  logic pcif_en;  logic [N_PCI-1:0] pci_en;
  logic [3:0] sdr_grp_en;    logic [N_REF-1:0] ref_en;  logic apic_en;
  logic [N_CPU-1:0] cpu_o;   logic pcif_o;   logic [N_PCI-1:0] pci_o;
  logic [SDR_N-1:0] sdr_o;   logic [N_REF-1:0] ref_o;   logic apic_o;
  logic cpu_oe, pcif_oe, pci_oe, ref_oe, apic_oe;  logic [SDR_N-1:0] sdr_oe;

  initial begin cpu_clk = 0; forever #5 cpu_clk = ~cpu_clk; end
  initial begin pci_clk = 0; #3; forever #15 pci_clk = ~pci_clk; end
  initial begin buf_clk = 0; #1; forever #5 buf_clk = ~buf_clk; end
  initial begin ref_clk = 0; forever #35 ref_clk = ~ref_clk; end

  clk_stop_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_REF(N_REF)) dut (
    .rst(rst), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .buf_clk(buf_clk), .ref_clk(ref_clk),
    .mobile(mobile), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .tristate(tristate),
    .cpu_en(cpu_en), .pcif_en(pcif_en), .pci_en(pci_en), .sdr_grp_en(sdr_grp_en),
    .ref_en(ref_en), .apic_en(apic_en), .cpu_o(cpu_o), .pcif_o(pcif_o), .pci_o(pci_o),
    .sdr_o(sdr_o), .ref_o(ref_o), .apic_o(apic_o), .cpu_oe(cpu_oe), .pcif_oe(pcif_oe),
    .pci_oe(pci_oe), .sdr_oe(sdr_oe), .ref_oe(ref_oe), .apic_oe(apic_oe));

  int checks = 0, errs = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ACT_W-1:0] act_vec();
    return {cpu_o, pcif_o, pci_o, ref_o, apic_o, sdr_o};
  endfunction
  function automatic logic [OE_W-1:0] oe_vec();
    return {cpu_oe, pcif_oe, pci_oe, ref_oe, apic_oe, sdr_oe};
  endfunction

  // Expected activity from R6-R10: bits 13,12,9,8 group 2; 11,10 group 3; 7-4 group 1; 3-0 group 0
  function automatic logic [ACT_W-1:0] exp_act();
    logic [SDR_N-1:0] sm;
    logic d;
    d  = sdr_grp_en[3] & ~mobile;
    sm = {sdr_grp_en[2], sdr_grp_en[2], d, d, sdr_grp_en[2], sdr_grp_en[2],
          {4{sdr_grp_en[1]}}, {4{sdr_grp_en[0]}}};
    return {cpu_en & {N_CPU{~mobile | cpu_stop_n}}, pcif_en,
            pci_en & {N_PCI{~mobile | pci_stop_n}}, ref_en, apic_en, sm};
  endfunction
  function automatic logic [OE_W-1:0] exp_oe();
    if (tristate) return '0;
    return {5'b11111, 2'b11, {2{~mobile}}, 10'h3FF};
  endfunction

  // Scoreboard
  typedef struct { string req; logic [ACT_W-1:0] act; logic [OE_W-1:0] oe; } exp_t;
  exp_t sb_q[$];
  exp_t item;
  bit mon_done;
  logic [ACT_W-1:0] acc;

  initial begin
    forever begin
      wait (sb_q.size() != 0);
      item = sb_q.pop_front();
      acc = '0;
      repeat (300) begin #1; acc = acc | act_vec(); end
      chk({item.req, " activity"}, 64'(acc), 64'(item.act));
      chk({item.req, " enables"}, 64'(oe_vec()), 64'(item.oe));
      mon_done = 1;
    end
  end

  task automatic expect_state(input string req);
    exp_t e;
    e.req = req; e.act = exp_act(); e.oe = exp_oe();
    mon_done = 0;
    sb_q.push_back(e);
    wait (mon_done);
  endtask

  task automatic settle();
    repeat (25) @(posedge cpu_clk);
  endtask

  // R12 pulse-width monitor
  bit trk = 0;
  int runts = 0, pulses = 0;
  time r_cpu = 0, r_pci = 0;
  always @(posedge cpu_o[0]) r_cpu = $time;
  always @(negedge cpu_o[0]) if (trk) begin pulses++; if ($time - r_cpu != 5) runts++; end
  always @(posedge pci_o[0]) r_pci = $time;
  always @(negedge pci_o[0]) if (trk) begin pulses++; if ($time - r_pci != 15) runts++; end

  task automatic cpu_timing(input logic lvl);
    @(posedge cpu_clk); #2; cpu_stop_n = lvl;
    @(posedge pci_clk); @(posedge pci_clk);
    @(posedge cpu_clk); @(posedge cpu_clk); #1;
    if (!lvl) begin
      chk("R2 last cpu pulse", 64'(cpu_o), 64'(2'b11));
      @(posedge cpu_clk); #1;
      chk("R2 cpu stopped", 64'(cpu_o), 0);
      repeat (5) @(posedge cpu_clk); #1;
      chk("R2 cpu held low", 64'(cpu_o), 0);
    end else begin
      chk("R3 cpu still low", 64'(cpu_o), 0);
      @(posedge cpu_clk); #1;
      chk("R3 cpu restarted", 64'(cpu_o), 64'(2'b11));
    end
  endtask

  task automatic pci_timing(input logic lvl);
    @(posedge cpu_clk); #2; pci_stop_n = lvl;
    @(posedge pci_clk); #1;
    chk(lvl ? "R5 edge1" : "R4 edge1", 64'(pci_o), lvl ? 0 : 64'h1f);
    @(posedge pci_clk); #1;
    chk(lvl ? "R5 edge2" : "R4 edge2", 64'(pci_o), lvl ? 0 : 64'h1f);
    @(posedge pci_clk); #1;
    chk(lvl ? "R5 edge3" : "R4 edge3", 64'(pci_o), lvl ? 64'h1f : 0);
    chk("R6 free-running during pci stop edge", 64'(pcif_o), 1);
  endtask

  initial begin
    rst = 1; mobile = 1; cpu_stop_n = 1; pci_stop_n = 1; tristate = 0;
    cpu_en = '1; pcif_en = 1; pci_en = '1; sdr_grp_en = '1; ref_en = '1; apic_en = 1;
    repeat (20) @(posedge ref_clk);
    @(posedge cpu_clk); #1;
    chk("R1 outputs in reset", 64'(act_vec()), 0);
    chk("R1 enables in reset", 64'(oe_vec()), 0);
    @(posedge cpu_clk); #2; rst = 0;
    repeat (30) @(posedge cpu_clk);
    trk = 1;
    expect_state("R8 all enabled mobile");

    cpu_timing(1'b0);
    cpu_timing(1'b1);
    pci_timing(1'b0);
    pci_timing(1'b1);

    @(posedge cpu_clk); #2; pci_stop_n = 0; settle();
    expect_state("R6 pci stop only");
    @(posedge cpu_clk); #2; pci_stop_n = 1; cpu_stop_n = 0; settle();
    expect_state("R6 cpu stop only");
    @(posedge cpu_clk); #2; mobile = 0; pci_stop_n = 0; settle();
    expect_state("R7 desktop ignores stops");
    @(posedge cpu_clk); #2; mobile = 1; cpu_stop_n = 1; pci_stop_n = 1;
    cpu_en = 2'b01; pcif_en = 0; pci_en = 5'b10101; ref_en = 2'b10; apic_en = 0; settle();
    expect_state("R8 sparse enables");
    @(posedge cpu_clk); #2; cpu_en = 2'b10; pcif_en = 1; pci_en = 5'b01010;
    ref_en = 2'b01; apic_en = 1; settle();
    expect_state("R8 alternate enables");
    @(posedge cpu_clk); #2; mobile = 0; sdr_grp_en = 4'b0101; settle();
    expect_state("R9 groups 0101");
    @(posedge cpu_clk); #2; sdr_grp_en = 4'b1010; settle();
    expect_state("R9 groups 1010");
    @(posedge cpu_clk); #2; mobile = 1; sdr_grp_en = 4'b1000; settle();
    expect_state("R10 desktop group in mobile");
    @(posedge cpu_clk); #2; sdr_grp_en = 4'b1111; tristate = 1; settle();
    expect_state("R11 three-state");
    @(posedge cpu_clk); #2; tristate = 0; mobile = 0; settle();
    expect_state("R11 enables restored");

    chk("R12 runt pulses", 64'(runts), 0);
    chk("R12 pulses observed", 64'(pulses > 0), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #200000;
    checks++; errs++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule